// File: doc/BRIEF.md
# Square-Root Carry-Select Adder, 16-bit

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum with a carry-out. It has no clock and no state: the result follows the inputs through logic alone. The word is cut into five slices whose widths grow from the low end. The lowest slice is a plain ripple chain fed by the external carry-in. Each higher slice computes its result for an incoming carry of 0 with one ripple chain. It then gets the result for an incoming carry of 1 from that first result. The carry coming up from the slice below chooses between the two.

In the default build, the carry-1 result comes from a binary-to-excess-1 incrementer. This incrementer adds one to the (n+1)-bit value made of the slice's n sum bits and its carry-out. A parameter switches each slice to a second ripple chain with carry-in tied high, for comparison. Every exclusive-OR in the full adders is built as NOT(a AND b) AND (a OR b).

Top module: `sqrt_csel_add16`

## Requirements
- R1: For every input, {carry_out, sum} equals op_a + op_b + carry_in, taken as a 17-bit unsigned value.
- R2: The slices are 2, 2, 3, 4 and 5 bits wide, from bit 0 upward. The lowest slice is a ripple chain driven directly by carry_in.
- R3: In the incrementer build (USE_INC=1), each higher slice's carry-1 result {carry, sum bits} equals its carry-0 result plus one, over n+1 bits.
- R4: Each higher slice outputs its carry-1 result when the carry from the slice below is 1, and its carry-0 result otherwise. A carry created at any slice boundary therefore reaches the top.
- R5: The incrementer returns its input plus one, wrapping modulo 2^(n+1). An all-ones input gives all zeros.
- R6: The full adder's sum bit equals a XOR b XOR cin, and its carry equals the majority of a, b and cin, for all eight input combinations.
- R7: The dual-ripple build (USE_INC=0) gives the same {carry_out, sum} as R1 for every tested vector.
- R8: All-ones operands with carry_in=1 give sum 16'hFFFF with carry_out 1. op_a=16'hFFFF, op_b=0, carry_in=1 gives sum 0 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bench drives a carry across each slice boundary: a run of ones below the boundary plus one. If a slice ignored the carry from below, or a multiplexer selected the wrong way, the upper bits of the sum would come out one too low. All-ones operands with and without carry-in test the top slice's carry and its incremented path. A wrong wrap in the incrementer would drop or invent carry_out there. The full adder is tested exhaustively, so a mistyped reduced XOR shows up as a flipped sum bit. The incrementer is tested on its all-ones input, where a missing wrap would leave stray ones. Random operands are run on both builds against a behavioural sum.

// File: rtl/sqcsa_pkg.sv
package sqcsa_pkg;
  localparam int NGRP = 5;

  function automatic int grp_w(input int i);
    case (i)
      0: return 2;
      1: return 2;
      2: return 3;
      3: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int grp_lo(input int i);
    int acc;
    acc = 0;
    for (int k = 0; k < i; k++) acc += grp_w(k);
    return acc;
  endfunction

  localparam int SUM_W = grp_lo(NGRP);

  // reduced-gate exclusive-OR
  function automatic logic xr(input logic x, input logic y);
    return ~(x & y) & (x | y);
  endfunction
endpackage

// File: rtl/csa_fa.sv
module csa_fa
  import sqcsa_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic co
);
  logic p;
  assign p  = xr(a, b);
  assign s  = xr(p, cin);
  assign co = (a & b) | (cin & p);

  always_comb begin
    a_r6_fa_truth: assert ({co, s} == {1'b0, a} + {1'b0, b} + {1'b0, cin})
      else $error("full adder output wrong");
  end
endmodule

// File: rtl/csa_rca.sv
module csa_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa_fa u_fa (.a(a[i]), .b(b[i]), .cin(c[i]), .s(s[i]), .co(c[i+1]));
  end

  assign co = c[W];

  always_comb begin
    a_r1_rca_sum: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})
      else $error("ripple chain sum wrong");
  end
endmodule

// File: rtl/csa_inc.sv
module csa_inc
  import sqcsa_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] v,
  output logic [W-1:0] q
);
  logic [W-1:0] run;
  assign run[0] = 1'b1;

  for (genvar i = 1; i < W; i++) begin : g_run
    assign run[i] = run[i-1] & v[i-1];
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    assign q[i] = xr(v[i], run[i]);
  end

  always_comb begin
    a_r5_wrap: assert (!(&v) || (q == '0))
      else $error("incrementer wrap wrong");
  end
endmodule

// File: rtl/csa_sel_group.sv
module csa_sel_group #(
  parameter int W       = 4,
  parameter bit USE_INC = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         csel,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s0, s1;
  logic         c0, c1;

  csa_rca #(.W(W)) u_rca0 (.a(a), .b(b), .cin(1'b0), .s(s0), .co(c0));

  if (USE_INC) begin : g_inc
    csa_inc #(.W(W+1)) u_inc (.v({c0, s0}), .q({c1, s1}));
  end else begin : g_dup
    csa_rca #(.W(W)) u_rca1 (.a(a), .b(b), .cin(1'b1), .s(s1), .co(c1));
  end

  assign {co, s} = csel ? {c1, s1} : {c0, s0};

  always_comb begin
    a_r3_one_above: assert ({c1, s1} == {c0, s0} + 1'b1)
      else $error("carry-1 path is not carry-0 path plus one");
    a_r4_group_sum: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{W{1'b0}}, csel})
      else $error("slice result inconsistent with incoming carry");
  end
endmodule

// File: rtl/sqrt_csel_add16.sv
module sqrt_csel_add16
  import sqcsa_pkg::*;
#(
  parameter bit USE_INC = 1'b1
) (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  output logic [15:0] sum,
  output logic        carry_out
);
  logic [NGRP:0] gc;
  assign gc[0] = carry_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    localparam int LO = grp_lo(g);
    localparam int W  = grp_w(g);
    if (g == 0) begin : g_base
      csa_rca #(.W(W)) u_base (
        .a(op_a[LO +: W]), .b(op_b[LO +: W]), .cin(gc[0]),
        .s(sum[LO +: W]), .co(gc[1]));
    end else begin : g_sel
      csa_sel_group #(.W(W), .USE_INC(USE_INC)) u_grp (
        .a(op_a[LO +: W]), .b(op_b[LO +: W]), .csel(gc[g]),
        .s(sum[LO +: W]), .co(gc[g+1]));
    end
  end

  assign carry_out = gc[NGRP];

  always_comb begin
    a_r1_total: assert ({carry_out, sum} == {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in})
      else $error("adder total wrong");
    a_r2_width: assert (SUM_W == 16)
      else $error("slice widths do not cover the word");
  end
endmodule

// File: tb/sqrt_csel_add16_bench.sv
module sqrt_csel_add16_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] a, b;
  logic        ci;
  logic [15:0] s_inc, s_dup;
  logic        co_inc, co_dup;

  sqrt_csel_add16 #(.USE_INC(1'b1)) u_sqrt_csel_add16 (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_inc), .carry_out(co_inc));
  sqrt_csel_add16 #(.USE_INC(1'b0)) u_dup (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_dup), .carry_out(co_dup));

  logic fa_a, fa_b, fa_c, fa_s, fa_co;
  csa_fa u_fa (.a(fa_a), .b(fa_b), .cin(fa_c), .s(fa_s), .co(fa_co));

  logic [4:0] iv, iq;
  csa_inc #(.W(5)) u_inc (.v(iv), .q(iq));

  function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h (a=%h b=%h ci=%b)", req, got, exp, a, b, ci);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] x, input logic [15:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    chk({req, " inc"}, {co_inc, s_inc}, model(x, y, c));
    chk({"R7 ", req}, {co_dup, s_dup}, model(x, y, c));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] m;
    void'($urandom(32'd2024));
    a = '0; b = '0; ci = 1'b0;
    fa_a = 0; fa_b = 0; fa_c = 0; iv = '0;

    // R1 zero state
    apply("R1 zeros", 16'h0000, 16'h0000, 1'b0);
    apply("R1 cin only", 16'h0000, 16'h0000, 1'b1);
    // R8 corners
    apply("R8 ones+cin", 16'hFFFF, 16'hFFFF, 1'b1);
    apply("R8 ones", 16'hFFFF, 16'hFFFF, 1'b0);
    apply("R8 ripple through", 16'hFFFF, 16'h0000, 1'b1);
    apply("R1 alt", 16'hAAAA, 16'h5555, 1'b0);
    apply("R1 alt cin", 16'hAAAA, 16'h5555, 1'b1);
    apply("R1 alt same", 16'h5555, 16'h5555, 1'b1);
    // R2/R4: carry created at each slice boundary (2,4,7,11)
    foreach (m[i]) begin
      if (i == 2 || i == 4 || i == 7 || i == 11) begin
        apply("R4 boundary", (16'h1 << i) - 16'h1, 16'h0001, 1'b0);
        apply("R2 boundary", (16'h1 << i) - 16'h1, 16'h0000, 1'b1);
      end
    end
    // R3 random, both variants
    for (int n = 0; n < 3000; n++) begin
      apply("R3 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R6 full adder truth table
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      {fa_a, fa_b, fa_c} = 3'(k);
      @(negedge clk);
      checks++;
      if ({fa_co, fa_s} !== (2'(fa_a) + 2'(fa_b) + 2'(fa_c))) begin
        failures++;
        $display("FAIL R6 fa in=%0d got=%b exp=%b", k, {fa_co, fa_s},
                 2'(fa_a) + 2'(fa_b) + 2'(fa_c));
      end
    end

    // R5 incrementer including wrap
    for (int k = 0; k < 32; k++) begin
      @(posedge clk);
      iv = 5'(k);
      @(negedge clk);
      checks++;
      if (iq !== 5'(k + 1)) begin
        failures++;
        $display("FAIL R5 inc in=%h got=%h exp=%h", iv, iq, 5'(k + 1));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule